// File: doc/BRIEF.md
# Power Domain Switch Command Sequencer

This block switches a set of power domains on and off under software control. Software first loads a selection mask for the domains to be powered up or for those to be powered down. It then writes a short coded sequence into a single command register. A small parser checks the codes in order. Only a complete, correctly ordered sequence starts a switch, so a stray or corrupted write cannot change power state.

Once a sequence is accepted, the block waits a programmable number of cycles to stand in for switch settling. It then updates the domain power-enable outputs and the readable power-state register, and records a completion event. Bad codes and requests that cannot be served are recorded as failure events. Two sticky status registers, each cleared by writing ones, hold these events. A mask register selects which of them drive the single interrupt line.

Top module: `pwr_dom_seq`

## Requirements
- R1: After reset the power state is 0x03 (domains 0 and 1 on), the interrupt mask reads 0x1FF (all sources masked), both status registers read 0, the settle count reads 8 and irq is low.
- R2: With the domain bits to power up held at offset 0x0C, writing 0xFF, 0x05, 0x50 to the command port at 0x44 turns those domains on and sets status bit 0 (done).
- R3: With the domain bits to power down held at offset 0x10, writing 0xFF, 0x0A, 0xA0 to the command port turns those domains off and sets status bit 0.
- R4: A command write other than 0xFF whose code is not the expected next one returns the parser to idle, sets status bit 2 and changes no power state. This includes any code other than 0xFF while idle.
- R5: Writing 0xFF to the command port at any point restarts the sequence, with no failure recorded.
- R6: A completed sequence that arrives while a switch is still settling, or whose selection mask is zero, sets status bit 3 and changes no power state.
- R7: Bit N of the power-state register at 0x80 and of dom_pwr_en is 1 exactly while domain N is powered.
- R8: The settle count register at 0x4C holds value S. The power state changes S+1 cycles after the write of the final code, and holds steady before that.
- R9: Writing ones to the event status register at 0x88 or to the interrupt status register at 0x8C clears those bits in that register only. Both registers record the same events: bit 0 done, bit 2 bad code, bit 3 rejected.
- R10: irq is high exactly when some interrupt status bit is set whose bit in the mask register at 0x48 is 0. A mask bit of 1 disables that source.
- R11: The selection registers store only the bits for the 7 implemented domains; higher bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; read data is returned in the same cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when bus_rd is low |
| dom_pwr_en | output | 7 | Power enable per domain |
| irq | output | 1 | Interrupt request |

## Verification
The command parser is tried with correct power-up and power-down sequences. It is also tried with a low code sent without the preceding restart, a high code that belongs to the opposite direction, and a restart inserted in the middle of a sequence. Together these show that only exact order is accepted and that 0xFF always re-arms the parser. Repeating a sequence while the first switch is still settling, and issuing one with an empty mask, separates the rejection path from the bad-code path. A zero settle count and a non-zero one confirm the exact cycle of the state change. A per-cycle model of the outputs catches any early or late change of dom_pwr_en or irq.

// File: rtl/pds_pkg.sv
package pds_pkg;

    localparam int PDS_NUM_DOM = 7;
    localparam int PDS_DATA_W  = 16;
    localparam int PDS_CNT_W   = 16;
    localparam int STAT_W      = 9;
    localparam int CODE_W      = 8;

    // register byte offsets
    localparam logic [7:0] OFS_ON_SEL  = 8'h0C;
    localparam logic [7:0] OFS_OFF_SEL = 8'h10;
    localparam logic [7:0] OFS_CMD     = 8'h44;
    localparam logic [7:0] OFS_MASK    = 8'h48;
    localparam logic [7:0] OFS_SETTLE  = 8'h4C;
    localparam logic [7:0] OFS_STATE   = 8'h80;
    localparam logic [7:0] OFS_EVENT   = 8'h88;
    localparam logic [7:0] OFS_INTR    = 8'h8C;

    // command codes
    localparam logic [CODE_W-1:0] CMD_RESTART = 8'hFF;
    localparam logic [CODE_W-1:0] CMD_UP_LO   = 8'h05;
    localparam logic [CODE_W-1:0] CMD_UP_HI   = 8'h50;
    localparam logic [CODE_W-1:0] CMD_DN_LO   = 8'h0A;
    localparam logic [CODE_W-1:0] CMD_DN_HI   = 8'hA0;

    // status bit positions
    localparam int ST_DONE = 0;
    localparam int ST_BAD  = 2;
    localparam int ST_REJ  = 3;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_ARMED = 2'd1,
        PS_UP_LO = 2'd2,
        PS_DN_LO = 2'd3
    } parse_st_e;

    typedef struct packed {
        logic go;
        logic up;
    } launch_t;

    typedef struct packed {
        logic rej;
        logic bad;
        logic done;
    } events_t;

    function automatic logic [STAT_W-1:0] pack_events(events_t e);
        logic [STAT_W-1:0] v;
        v          = '0;
        v[ST_DONE] = e.done;
        v[ST_BAD]  = e.bad;
        v[ST_REJ]  = e.rej;
        return v;
    endfunction

endpackage

// File: rtl/pds_cmd_parser.sv
module pds_cmd_parser
    import pds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [CODE_W-1:0] cmd_code,
    output launch_t           req,
    output logic              bad_code
);

    parse_st_e st_q, st_d;

    always_comb begin
        st_d     = st_q;
        req      = '0;
        bad_code = 1'b0;
        if (cmd_wr) begin
            if (cmd_code == CMD_RESTART) begin
                st_d = PS_ARMED;
            end else begin
                unique case (st_q)
                    PS_IDLE: bad_code = 1'b1;
                    PS_ARMED: begin
                        if (cmd_code == CMD_UP_LO)      st_d = PS_UP_LO;
                        else if (cmd_code == CMD_DN_LO) st_d = PS_DN_LO;
                        else                            bad_code = 1'b1;
                    end
                    PS_UP_LO: begin
                        if (cmd_code == CMD_UP_HI) begin
                            req.go = 1'b1;
                            req.up = 1'b1;
                            st_d   = PS_IDLE;
                        end else begin
                            bad_code = 1'b1;
                        end
                    end
                    PS_DN_LO: begin
                        if (cmd_code == CMD_DN_HI) begin
                            req.go = 1'b1;
                            req.up = 1'b0;
                            st_d   = PS_IDLE;
                        end else begin
                            bad_code = 1'b1;
                        end
                    end
                    default: bad_code = 1'b1;
                endcase
                if (bad_code) st_d = PS_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PS_IDLE;
        else     st_q <= st_d;
    end

    // R5: restart code always re-arms the parser
    a_r5_restart_arms: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_code == CMD_RESTART) |=> (st_q == PS_ARMED));

    // R4: a mismatching code leaves the parser idle
    a_r4_bad_to_idle: assert property (@(posedge clk) disable iff (rst)
        bad_code |=> (st_q == PS_IDLE));

endmodule

// File: rtl/pds_switch_timer.sv
module pds_switch_timer
    import pds_pkg::*;
#(
    parameter int                  NUM_DOM  = PDS_NUM_DOM,
    parameter int                  CNT_W    = PDS_CNT_W,
    parameter logic [NUM_DOM-1:0]  RESET_ON = NUM_DOM'(3)
) (
    input  logic               clk,
    input  logic               rst,
    input  launch_t            req,
    input  logic [NUM_DOM-1:0] sel_up,
    input  logic [NUM_DOM-1:0] sel_dn,
    input  logic [CNT_W-1:0]   settle,
    output logic [NUM_DOM-1:0] dom_state,
    output logic               applied,
    output logic               rejected
);

    logic               busy_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_DOM-1:0] tgt_q;
    logic               tgt_up_q;
    logic [NUM_DOM-1:0] state_q;
    logic [NUM_DOM-1:0] chosen;
    logic               accept;

    assign chosen    = req.up ? sel_up : sel_dn;
    assign accept    = req.go && !busy_q && (chosen != '0);
    assign rejected  = req.go && !accept;
    assign applied   = busy_q && (cnt_q == '0);
    assign dom_state = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            cnt_q    <= '0;
            tgt_q    <= '0;
            tgt_up_q <= 1'b0;
            state_q  <= RESET_ON;
        end else begin
            if (busy_q) begin
                if (cnt_q == '0) begin
                    busy_q  <= 1'b0;
                    state_q <= tgt_up_q ? (state_q | tgt_q) : (state_q & ~tgt_q);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            if (accept) begin
                busy_q   <= 1'b1;
                cnt_q    <= settle;
                tgt_q    <= chosen;
                tgt_up_q <= req.up;
            end
        end
    end

    // R8: power state holds until the settle count runs out
    a_r8_hold_until_settled: assert property (@(posedge clk) disable iff (rst)
        !applied |=> $stable(state_q));

    // R6: a pending switch keeps its target while it settles
    a_r6_target_kept: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !applied) |=> (busy_q && $stable(tgt_q)));

endmodule

// File: rtl/pds_status.sv
module pds_status
    import pds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] ev,
    input  logic              clr_evt,
    input  logic              clr_int,
    input  logic [STAT_W-1:0] clr_val,
    input  logic [STAT_W-1:0] mask,
    output logic [STAT_W-1:0] evt_q,
    output logic [STAT_W-1:0] int_q,
    output logic              irq
);

    logic [STAT_W-1:0] evt_clr, int_clr;

    assign evt_clr = clr_evt ? clr_val : '0;
    assign int_clr = clr_int ? clr_val : '0;
    assign irq     = |(int_q & ~mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
            int_q <= '0;
        end else begin
            evt_q <= (evt_q & ~evt_clr) | ev;
            int_q <= (int_q & ~int_clr) | ev;
        end
    end

    // R9: cleared bits stay clear when no new event arrives
    a_r9_clear_sticks: assert property (@(posedge clk) disable iff (rst)
        (clr_int && ev == '0) |=> ((int_q & $past(clr_val)) == '0));

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
    import pds_pkg::*;
#(
    parameter int                 NUM_DOM        = PDS_NUM_DOM,
    parameter int                 DATA_W         = PDS_DATA_W,
    parameter int                 CNT_W          = PDS_CNT_W,
    parameter logic [NUM_DOM-1:0] RESET_ON       = NUM_DOM'(3),
    parameter int                 DEFAULT_SETTLE = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_DOM-1:0] dom_pwr_en,
    output logic               irq
);

    logic [NUM_DOM-1:0] sel_up_q, sel_dn_q;
    logic [STAT_W-1:0]  mask_q;
    logic [CNT_W-1:0]   settle_q;

    launch_t            req;
    logic               bad_code;
    logic [NUM_DOM-1:0] dom_state;
    logic               applied, rejected;
    logic [STAT_W-1:0]  ev_vec, evt_q, int_q;
    events_t            evs;
    logic               wr_cmd, clr_evt, clr_int;

    assign wr_cmd  = bus_wr && (bus_addr == OFS_CMD);
    assign clr_evt = bus_wr && (bus_addr == OFS_EVENT);
    assign clr_int = bus_wr && (bus_addr == OFS_INTR);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_up_q <= '0;
            sel_dn_q <= '0;
            mask_q   <= '1;
            settle_q <= CNT_W'(DEFAULT_SETTLE);
        end else if (bus_wr) begin
            if (bus_addr == OFS_ON_SEL)  sel_up_q <= bus_wdata[NUM_DOM-1:0];
            if (bus_addr == OFS_OFF_SEL) sel_dn_q <= bus_wdata[NUM_DOM-1:0];
            if (bus_addr == OFS_MASK)    mask_q   <= bus_wdata[STAT_W-1:0];
            if (bus_addr == OFS_SETTLE)  settle_q <= bus_wdata[CNT_W-1:0];
        end
    end

    pds_cmd_parser u_parser (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (wr_cmd),
        .cmd_code (bus_wdata[CODE_W-1:0]),
        .req      (req),
        .bad_code (bad_code)
    );

    pds_switch_timer #(
        .NUM_DOM  (NUM_DOM),
        .CNT_W    (CNT_W),
        .RESET_ON (RESET_ON)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .sel_up    (sel_up_q),
        .sel_dn    (sel_dn_q),
        .settle    (settle_q),
        .dom_state (dom_state),
        .applied   (applied),
        .rejected  (rejected)
    );

    always_comb begin
        evs.done = applied;
        evs.bad  = bad_code;
        evs.rej  = rejected;
        ev_vec   = pack_events(evs);
    end

    pds_status u_status (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev_vec),
        .clr_evt (clr_evt),
        .clr_int (clr_int),
        .clr_val (bus_wdata[STAT_W-1:0]),
        .mask    (mask_q),
        .evt_q   (evt_q),
        .int_q   (int_q),
        .irq     (irq)
    );

    assign dom_pwr_en = dom_state;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                OFS_ON_SEL:  bus_rdata[NUM_DOM-1:0] = sel_up_q;
                OFS_OFF_SEL: bus_rdata[NUM_DOM-1:0] = sel_dn_q;
                OFS_MASK:    bus_rdata[STAT_W-1:0]  = mask_q;
                OFS_SETTLE:  bus_rdata[CNT_W-1:0]   = settle_q;
                OFS_STATE:   bus_rdata[NUM_DOM-1:0] = dom_state;
                OFS_EVENT:   bus_rdata[STAT_W-1:0]  = evt_q;
                OFS_INTR:    bus_rdata[STAT_W-1:0]  = int_q;
                default:     bus_rdata = '0;
            endcase
        end
    end

    // R2: a finished switch records completion
    a_r2_done_recorded: assert property (@(posedge clk) disable iff (rst)
        applied |=> evt_q[ST_DONE]);

    // R6: an unserviceable request records a rejection
    a_r6_reject_recorded: assert property (@(posedge clk) disable iff (rst)
        rejected |=> int_q[ST_REJ]);

    // R10: with every source masked the line stays low
    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (&mask_q) |-> !irq);

endmodule

// File: tb/tb_pwr_dom_seq.sv
module tb_pwr_dom_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic [6:0]  dom_pwr_en;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    pwr_dom_seq dut (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .dom_pwr_en (dom_pwr_en),
        .irq        (irq)
    );

    // behavioural reference model
    logic [31:0] m_state, m_up, m_dn, m_mask, m_settle, m_evt, m_int;
    logic [31:0] m_rem, m_tgt;
    int          m_phase;
    bit          m_busy, m_dir;

    always @(posedge clk) begin
        logic [31:0] ev, ce, ci, sel, code;
        bit was_busy, go, bad;
        if (rst) begin
            m_state = 32'h3; m_up = 0; m_dn = 0; m_mask = 32'h1FF;
            m_settle = 8; m_evt = 0; m_int = 0; m_rem = 0; m_tgt = 0;
            m_phase = 0; m_busy = 0; m_dir = 0;
        end else begin
            ev = 0; ce = 0; ci = 0;
            was_busy = m_busy;
            if (was_busy) begin
                if (m_rem == 0) begin
                    if (m_dir) m_state = m_state | m_tgt;
                    else       m_state = m_state & ~m_tgt & 32'h7F;
                    m_busy = 0;
                    ev = ev | 32'h1;
                end else begin
                    m_rem = m_rem - 1;
                end
            end
            if (bus_wr) begin
                case (bus_addr)
                    8'h0C: m_up = {16'h0, bus_wdata} & 32'h7F;
                    8'h10: m_dn = {16'h0, bus_wdata} & 32'h7F;
                    8'h48: m_mask = {16'h0, bus_wdata} & 32'h1FF;
                    8'h4C: m_settle = {16'h0, bus_wdata};
                    8'h88: ce = {16'h0, bus_wdata} & 32'h1FF;
                    8'h8C: ci = {16'h0, bus_wdata} & 32'h1FF;
                    8'h44: begin
                        code = {24'h0, bus_wdata[7:0]};
                        go = 0; bad = 0;
                        if (code == 32'hFF) m_phase = 1;
                        else if (m_phase == 1 && code == 32'h05) m_phase = 2;
                        else if (m_phase == 1 && code == 32'h0A) m_phase = 3;
                        else if (m_phase == 2 && code == 32'h50) begin go = 1; m_dir = 1; m_phase = 0; end
                        else if (m_phase == 3 && code == 32'hA0) begin go = 1; m_dir = 0; m_phase = 0; end
                        else bad = 1;
                        if (bad) begin ev = ev | 32'h4; m_phase = 0; end
                        if (go) begin
                            sel = m_dir ? m_up : m_dn;
                            if (was_busy || sel == 0) ev = ev | 32'h8;
                            else begin m_busy = 1; m_rem = m_settle; m_tgt = sel; end
                        end
                    end
                    default: ;
                endcase
            end
            m_evt = (m_evt & ~ce) | ev;
            m_int = (m_int & ~ci) | ev;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R7, R10)
    always @(negedge clk) begin
        if (!rst) begin
            check("R7 dom_pwr_en vs model", {25'h0, dom_pwr_en}, m_state);
            check("R10 irq vs model", {31'h0, irq},
                  {31'h0, ((m_int & ~m_mask & 32'h1FF) != 0)});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        check(tag, {16'h0, bus_rdata}, {16'h0, exp});
        bus_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_all();
        wr(8'h88, 16'h1FF);
        wr(8'h8C, 16'h1FF);
    endtask

    task automatic seq(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        wr(8'h44, {8'h0, a});
        wr(8'h44, {8'h0, b});
        wr(8'h44, {8'h0, c});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h80, 16'h003, "R1 power state after reset");
        rd(8'h48, 16'h1FF, "R1 mask after reset");
        rd(8'h8C, 16'h000, "R1 int status after reset");
        rd(8'h88, 16'h000, "R1 event status after reset");
        rd(8'h4C, 16'h008, "R1 settle after reset");
        check("R1 irq low after reset", {31'h0, irq}, 0);

        // R8 settle register, R2 power-up with exact timing
        wr(8'h4C, 16'd3);
        rd(8'h4C, 16'd3, "R8 settle readback");
        wr(8'h0C, 16'h04);
        seq(8'hFF, 8'h05, 8'h50);
        check("R8 no change at launch", {25'h0, dom_pwr_en}, 32'h03);
        wait_cyc(3);
        check("R8 no change before settle end", {25'h0, dom_pwr_en}, 32'h03);
        wait_cyc(1);
        check("R2 domain 2 on after settle", {25'h0, dom_pwr_en}, 32'h07);
        rd(8'h8C, 16'h001, "R2 done bit set");
        rd(8'h80, 16'h007, "R7 state register");

        // R10 unmask, R9 independent clears
        wr(8'h48, 16'h1FE);
        check("R10 irq when done unmasked", {31'h0, irq}, 1);
        wr(8'h8C, 16'h001);
        check("R10 irq low after clear", {31'h0, irq}, 0);
        rd(8'h8C, 16'h000, "R9 int status cleared");
        rd(8'h88, 16'h001, "R9 event status kept");
        wr(8'h88, 16'h1FF);
        rd(8'h88, 16'h000, "R9 event status cleared");

        // R3 power-down of two domains
        wr(8'h10, 16'h06);
        seq(8'hFF, 8'h0A, 8'hA0);
        wait_cyc(5);
        rd(8'h80, 16'h001, "R3 domains 1,2 off");
        rd(8'h88, 16'h001, "R3 done bit set");
        clear_all();

        // R4 low code without restart, then wrong high code
        wr(8'h44, 16'h05);
        rd(8'h8C, 16'h004, "R4 code while idle fails");
        clear_all();
        seq(8'hFF, 8'h05, 8'hA0);
        rd(8'h8C, 16'h004, "R4 mismatched high code fails");
        wait_cyc(6);
        rd(8'h80, 16'h001, "R4 no state change");
        clear_all();

        // R5 restart mid-sequence
        wr(8'h10, 16'h01);
        wr(8'h44, 16'hFF);
        wr(8'h44, 16'h05);
        seq(8'hFF, 8'h0A, 8'hA0);
        wait_cyc(5);
        rd(8'h80, 16'h000, "R5 restart then power-down");
        rd(8'h8C, 16'h001, "R5 no failure recorded");
        clear_all();

        // R6 busy rejection
        wr(8'h4C, 16'd20);
        wr(8'h0C, 16'h10);
        seq(8'hFF, 8'h05, 8'h50);
        seq(8'hFF, 8'h05, 8'h50);
        rd(8'h8C, 16'h008, "R6 rejected while settling");
        wait_cyc(25);
        rd(8'h80, 16'h010, "R6 first request completes");
        rd(8'h8C, 16'h009, "R6 done and reject both set");
        clear_all();

        // R6 empty selection
        wr(8'h0C, 16'h00);
        seq(8'hFF, 8'h05, 8'h50);
        rd(8'h8C, 16'h008, "R6 empty selection rejected");
        wait_cyc(25);
        rd(8'h80, 16'h010, "R6 empty selection no change");

        // R11 selection width
        wr(8'h0C, 16'hFFFF);
        rd(8'h0C, 16'h07F, "R11 up selection width");
        wr(8'h10, 16'h8040);
        rd(8'h10, 16'h040, "R11 down selection width");

        // R10 all masked
        wr(8'h48, 16'h1FF);
        check("R10 irq low with all masked", {31'h0, irq}, 0);

        // R8 zero settle
        clear_all();
        wr(8'h4C, 16'd0);
        wr(8'h0C, 16'h01);
        seq(8'hFF, 8'h05, 8'h50);
        check("R8 zero settle before edge", {25'h0, dom_pwr_en}, 32'h10);
        wait_cyc(1);
        check("R8 zero settle one cycle later", {25'h0, dom_pwr_en}, 32'h11);

        wait_cyc(2);
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule